// File: doc/BRIEF.md
# Lock-Step Stream Broadcaster

This block copies each word of one incoming stream onto several outgoing streams. Every stream uses a valid bit and a data field, and the receiver returns an acknowledge for the word it is shown. The block has N_BRANCH output branches, with two as the default. The block takes a word into a holding register. It then shows that word on every branch in the same cycle and waits until each branch has acknowledged it. The incoming word is acknowledged only after all branches have taken it.

Each branch keeps a delivered flag for the current word. When a branch acknowledges, its valid drops and stays low for the rest of that word, so the branch cannot take the word twice. The upstream acknowledge rises in the single cycle in which the last outstanding branch acknowledges. In that same cycle the holding register is emptied and every delivered flag is cleared, so no branch can move on to the next word before the others. Reset is synchronous and active high.

Top module: `stream_bcast`

## Requirements
- R1: While `rst` is high at a clock edge, every `out_valid` bit is 0 after that edge and `in_ack` is 0 while no branch acknowledge is applied.
- R2: When the block is empty and `in_valid` is 1 at a clock edge, every bit of `out_valid` is 1 after that edge. Each branch's `out_data` slice (bits b*DATA_W upward for branch b) then carries the captured word.
- R3: While a branch's `out_valid` is 1, its `out_data` slice holds the captured word unchanged, even if `in_data` changes.
- R4: After a cycle in which `out_valid[b]` and `out_ack[b]` are both 1, `out_valid[b]` is 0 until the next word is captured.
- R5: `in_ack` is 1 in exactly the cycle in which the last branch that has not yet taken the word asserts its acknowledge. It is 1 for one cycle per word, and every `out_valid` bit is 0 in the following cycle.
- R6: A branch never sees a new word while another branch has not yet taken the current one; the next capture happens only after `in_ack`.
- R7: An `out_ack[b]` applied while `out_valid[b]` is 0 is ignored: it neither raises `in_ack` nor counts as a delivery.
- R8: If all branches acknowledge in the same cycle, `in_ack` is 1 in that cycle.
- R9: With no word held, `in_ack` stays 0 and every `out_valid` bit stays 0.
- R10: Every branch receives the same sequence of words in the order sent, and the number of `in_ack` pulses equals the number of words sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Upstream word present |
| in_data | input | DATA_W | Upstream word |
| in_ack | output | 1 | Upstream word taken by all branches |
| out_valid | output | N_BRANCH | Per-branch word present |
| out_data | output | N_BRANCH*DATA_W | Per-branch word, branch b at bits b*DATA_W upward |
| out_ack | input | N_BRANCH | Per-branch acknowledge |

## Verification
The bench builds the block with its defaults: two branches and 8-bit data. With two branches, the branch that finishes first, the branch that finishes last and the case where both acknowledge together can each be set up directly from a table of acknowledge delays. An 8-bit word is wide enough to use all-zero, all-one and alternating patterns. In every word the upstream data is scrambled after capture, which exposes any output that follows `in_data` instead of the held copy. Some table rows keep an acknowledge high after that branch is done, which exercises the rule that such an acknowledge is ignored.

// File: rtl/stream_bcast_pkg.sv
package stream_bcast_pkg;

    typedef enum logic {
        SLOT_EMPTY = 1'b0,
        SLOT_FULL  = 1'b1
    } slot_state_e;

    // A branch counts as finished for the current word once it has been
    // delivered, or in the cycle it accepts the word it is being shown.
    function automatic logic branch_finished(
        input logic delivered,
        input logic shown,
        input logic accept
    );
        return delivered | (shown & accept);
    endfunction

endpackage

// File: rtl/stream_bcast_slot.sv
module stream_bcast_slot
    import stream_bcast_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    input  logic              release_i,
    output logic              full_o,
    output logic [DATA_W-1:0] data_o
);

    slot_state_e       state_q;
    logic [DATA_W-1:0] data_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SLOT_EMPTY;
            data_q  <= '0;
        end else begin
            unique case (state_q)
                SLOT_EMPTY: begin
                    if (in_valid) begin
                        state_q <= SLOT_FULL;
                        data_q  <= in_data;
                    end
                end
                SLOT_FULL: begin
                    if (release_i) begin
                        state_q <= SLOT_EMPTY;
                    end
                end
                default: state_q <= SLOT_EMPTY;
            endcase
        end
    end

    assign full_o = (state_q == SLOT_FULL);
    assign data_o = data_q;

    // R2: an idle slot captures the presented word at the next edge
    a_r2_capture_word: assert property (@(posedge clk) disable iff (rst)
        (!full_o && in_valid) |=> (full_o && data_o == $past(in_data)));

    // R6: a held word is kept until it is released
    a_r6_hold_until_release: assert property (@(posedge clk) disable iff (rst)
        (full_o && !release_i) |=> (full_o && $stable(data_o)));

endmodule

// File: rtl/stream_bcast_branch.sv
module stream_bcast_branch
    import stream_bcast_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              word_full,
    input  logic [DATA_W-1:0] word_data,
    input  logic              word_release,
    input  logic              ack_i,
    output logic              valid_o,
    output logic [DATA_W-1:0] data_o,
    output logic              finished_o
);

    logic delivered_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            delivered_q <= 1'b0;
        end else if (word_release) begin
            delivered_q <= 1'b0;
        end else if (valid_o && ack_i) begin
            delivered_q <= 1'b1;
        end
    end

    assign valid_o    = word_full & ~delivered_q;
    assign data_o     = word_data;
    assign finished_o = branch_finished(delivered_q, valid_o, ack_i);

    // R4: a branch that accepted the word is not shown it again
    a_r4_no_repeat: assert property (@(posedge clk) disable iff (rst)
        (valid_o && ack_i) |=> !valid_o);

    // R3: a shown, unaccepted word stays on the branch unchanged
    a_r3_data_stable: assert property (@(posedge clk) disable iff (rst)
        (valid_o && !ack_i) |=> (valid_o && $stable(data_o)));

    // R7: an acknowledge without a shown word does not mark delivery
    a_r7_stray_ack: assert property (@(posedge clk) disable iff (rst)
        (!valid_o && !delivered_q && ack_i) |=> !delivered_q);

endmodule

// File: rtl/stream_bcast.sv
module stream_bcast
    import stream_bcast_pkg::*;
#(
    parameter int N_BRANCH = 2,
    parameter int DATA_W   = 8
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         in_valid,
    input  logic [DATA_W-1:0]            in_data,
    output logic                         in_ack,
    output logic [N_BRANCH-1:0]          out_valid,
    output logic [N_BRANCH*DATA_W-1:0]   out_data,
    input  logic [N_BRANCH-1:0]          out_ack
);

    localparam int BUS_W = N_BRANCH * DATA_W;

    logic                slot_full;
    logic [DATA_W-1:0]   slot_data;
    logic [N_BRANCH-1:0] finished;
    logic                word_release;

    stream_bcast_slot #(
        .DATA_W (DATA_W)
    ) slot_i (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .release_i (word_release),
        .full_o    (slot_full),
        .data_o    (slot_data)
    );

    for (genvar b = 0; b < N_BRANCH; b++) begin : g_branch
        stream_bcast_branch #(
            .DATA_W (DATA_W)
        ) branch_i (
            .clk          (clk),
            .rst          (rst),
            .word_full    (slot_full),
            .word_data    (slot_data),
            .word_release (word_release),
            .ack_i        (out_ack[b]),
            .valid_o      (out_valid[b]),
            .data_o       (out_data[b*DATA_W +: DATA_W]),
            .finished_o   (finished[b])
        );
    end

    assign word_release = slot_full & (&finished);
    assign in_ack       = word_release;

    // R1: reset clears every branch valid
    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (out_valid == '0));

    // R5: after the upstream acknowledge no branch shows a word
    a_r5_release_empties: assert property (@(posedge clk) disable iff (rst)
        in_ack |=> (out_valid == '0 && !in_ack));

    // R5: the upstream acknowledge coincides with a branch accepting
    a_r5_ack_with_take: assert property (@(posedge clk) disable iff (rst)
        in_ack |-> ((out_valid & out_ack) != '0));

    // R6: branches are shown a word together or not at all, apart from
    // those that already accepted it
    a_r6_lockstep_start: assert property (@(posedge clk) disable iff (rst)
        ($past(out_valid) == '0 && out_valid != '0) |-> (&out_valid));

    // R9: no word held means no acknowledge upstream
    a_r9_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        (out_valid == '0) |-> !in_ack);

    if (BUS_W < DATA_W) begin : g_bad_width
        initial $error("bus width below data width");
    end

endmodule

// File: tb/stream_bcast_tb_top.sv
module stream_bcast_tb_top;

    localparam int NB = 2;
    localparam int DW = 8;
    localparam int NV = 8;

    // {data[16:9], delay0[8:5], delay1[4:1], sticky[0]}
    localparam logic [16:0] VEC [0:NV-1] = '{
        {8'hA5, 4'd0, 4'd0, 1'b0},
        {8'h3C, 4'd2, 4'd0, 1'b0},
        {8'h00, 4'd0, 4'd3, 1'b0},
        {8'hFF, 4'd5, 4'd1, 1'b1},
        {8'h81, 4'd1, 4'd4, 1'b1},
        {8'h5A, 4'd3, 4'd3, 1'b0},
        {8'h7E, 4'd7, 4'd2, 1'b0},
        {8'h12, 4'd0, 4'd6, 1'b1}
    };

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             in_valid = 1'b0;
    logic [DW-1:0]    in_data = '0;
    logic             in_ack;
    logic [NB-1:0]    out_valid;
    logic [NB*DW-1:0] out_data;
    logic [NB-1:0]    out_ack = '0;

    int n_checks = 0;
    int n_errors = 0;
    int words_sent = 0;
    int acks_seen = 0;
    bit finished_run = 1'b0;

    always #5 clk = ~clk;

    stream_bcast #(.N_BRANCH(NB), .DATA_W(DW)) dut_i (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .in_ack    (in_ack),
        .out_valid (out_valid),
        .out_data  (out_data),
        .out_ack   (out_ack)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        if (!finished_run) begin
            finished_run = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    endtask

    // One word through the block with per-branch acknowledge delays.
    task automatic send_word(input logic [DW-1:0] d, input int dl0, input int dl1, input bit sticky);
        int  dly [NB];
        int  waited [NB];
        bit  done [NB];
        bit  over;
        logic exp_ack;
        dly[0] = dl0; dly[1] = dl1;
        for (int b = 0; b < NB; b++) begin waited[b] = 0; done[b] = 1'b0; end
        over = 1'b0;
        in_valid = 1'b1;
        in_data  = d;
        words_sent++;
        @(negedge clk);
        check(out_valid == 2'b11, "R2 all branches shown", out_valid, 2'b11);
        in_data = ~d;
        for (int cyc = 0; cyc < 40 && !over; cyc++) begin
            if (cyc > 0) @(negedge clk);
            exp_ack = 1'b1;
            for (int b = 0; b < NB; b++) begin
                if (done[b]) begin
                    check(out_valid[b] == 1'b0, "R4 valid drops after ack", out_valid[b], 0);
                    out_ack[b] = sticky;
                end else begin
                    check(out_valid[b] == 1'b1, "R6 valid held until own ack", out_valid[b], 1);
                    check(out_data[b*DW +: DW] == d, "R3 R10 branch data", out_data[b*DW +: DW], d);
                    out_ack[b] = (waited[b] >= dly[b]);
                    waited[b]++;
                    if (!out_ack[b]) exp_ack = 1'b0;
                end
            end
            #1;
            check(in_ack == exp_ack, sticky ? "R7 R5 upstream ack timing" : "R5 R8 upstream ack timing",
                  in_ack, exp_ack);
            if (in_ack) begin
                acks_seen++;
                over = 1'b1;
            end
            for (int b = 0; b < NB; b++) if (out_ack[b]) done[b] = 1'b1;
        end
        check(over, "R5 word completed", over, 1);
        @(negedge clk);
        in_valid = 1'b0;
        out_ack  = '0;
        check(out_valid == 2'b00, "R5 empty after upstream ack", out_valid, 0);
        #1;
        check(in_ack == 1'b0, "R5 single ack pulse", in_ack, 0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        check(out_valid == 2'b00, "R1 reset valid", out_valid, 0);
        check(in_ack == 1'b0, "R1 reset ack", in_ack, 0);
        rst = 1'b0;

        // R9 idle: nothing shown, nothing acknowledged
        repeat (3) begin
            @(negedge clk);
            check(out_valid == 2'b00, "R9 idle valid", out_valid, 0);
            check(in_ack == 1'b0, "R9 idle ack", in_ack, 0);
        end

        // R7 stray acknowledges while idle
        out_ack = 2'b11;
        repeat (3) begin
            @(negedge clk);
            #1;
            check(in_ack == 1'b0, "R7 stray ack idle", in_ack, 0);
            check(out_valid == 2'b00, "R7 stray ack no word", out_valid, 0);
        end
        out_ack = '0;

        // table walk: R2 R3 R4 R5 R6 R7 R8 R10
        for (int v = 0; v < NV; v++) begin
            send_word(VEC[v][16:9], int'(VEC[v][8:5]), int'(VEC[v][4:1]), VEC[v][0]);
        end

        // R8 back-to-back simultaneous acknowledge
        send_word(8'hC3, 0, 0, 1'b0);

        // R10 all words taken once upstream
        check(acks_seen == words_sent, "R10 ack count", acks_seen, words_sent);

        // R1 reset in the middle of a word
        in_valid = 1'b1;
        in_data  = 8'h66;
        @(negedge clk);
        in_valid = 1'b0;
        check(out_valid == 2'b11, "R2 word shown before reset", out_valid, 3);
        rst = 1'b1;
        @(negedge clk);
        check(out_valid == 2'b00, "R1 mid-word reset valid", out_valid, 0);
        #1;
        check(in_ack == 1'b0, "R1 mid-word reset ack", in_ack, 0);
        rst = 1'b0;
        @(negedge clk);
        check(out_valid == 2'b00, "R1 stays empty after reset", out_valid, 0);

        // R10 block still works after reset
        send_word(8'h99, 2, 1, 1'b0);
        check(acks_seen == words_sent, "R10 ack count after reset", acks_seen, words_sent);

        finish_run();
    end

endmodule